// File: doc/BRIEF.md
# On-Screen Display Frame Controller

This block holds the frame-level control state of an on-screen display overlay. A host writes two small registers: a frame control byte carrying a master display enable, two window enables, a page-wipe command and a transparency override, and a blink byte carrying a 5-bit period. The block combines the master and window enables into two window-active outputs. It decides, one pixel at a time, whether a palette result is transparent. It also produces a blink phase that flips every eight vertical fields per unit of the programmed period.

The display page memory lies outside the block and is written through the block's memory write port. In normal operation the host's memory write requests pass straight through. When the host sets the wipe bit, the block takes over the port and writes zero to every one of the 512 locations, one address per clock. While this runs, host memory writes are dropped and the wipe bit reads back as set. The bit falls back to zero on its own when the wipe ends.

Top module: `osd_frame_ctrl`

## Requirements
- R1: After reset, both window outputs are 0, `clr_busy` is 0, `blink_visible` is 1, and both registers read back as 0x00.
- R2: Frame control byte (`reg_sel`=0): bit 0 is the master enable, bit 1 is window A enable, bit 2 is window B enable, bit 3 is the wipe command and bit 4 is the transparency override. `win_a_on` equals master AND window A enable, and `win_b_on` equals master AND window B enable. Both take effect in the cycle after the write.
- R3: When the master enable is 0, both window outputs are 0 whatever the window enable bits hold.
- R4: Reading the frame control byte returns bits 0, 1, 2 and 4 as last written, bit 3 as the wipe-in-progress state, and zero in bits 7:5. Reading the blink byte (`reg_sel`=1) returns the period in bits 4:0 and zero above.
- R5: Writing 1 to bit 3 while idle starts a wipe in the next cycle. For 512 consecutive cycles `mem_we` is 1, `mem_wdata` is 0 and `mem_addr` steps from 0 up to 511, with `clr_busy` high throughout. After that `clr_busy` and read-back bit 3 return to 0.
- R6: Outside a wipe, the host memory write request, address and data appear on the memory port in the same cycle. During a wipe the host requests have no effect on the port.
- R7: Writing 1 to bit 3 during a wipe does not restart the address sequence, while the other bits of that write still take effect.
- R8: With period P > 0, `blink_visible` inverts on the 8·P-th `vsync` pulse counted from the last inversion or from the last write to the blink byte, and at no other time.
- R9: With period 0, `blink_visible` is 1 and `vsync` has no effect on it. Writing 0 to the period forces it to 1 in the next cycle.
- R10: `pix_transparent` is 1 exactly when the override bit is 0, `pix_color` is 0x00 and `pix_attr` is below 8. The output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: frame control byte, 1: blink byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| vsync | input | 1 | Single-cycle vertical field pulse |
| host_we | input | 1 | Host page memory write request |
| host_addr | input | 9 | Host page memory address |
| host_wdata | input | 16 | Host page memory data |
| mem_we | output | 1 | Page memory write enable |
| mem_addr | output | 9 | Page memory address |
| mem_wdata | output | 16 | Page memory write data |
| clr_busy | output | 1 | Wipe in progress |
| win_a_on | output | 1 | Window A active |
| win_b_on | output | 1 | Window B active |
| blink_visible | output | 1 | Blink phase, 1 = shown |
| pix_attr | input | 4 | Palette attribute index of the current pixel |
| pix_color | input | 8 | Palette lookup result of the current pixel |
| pix_transparent | output | 1 | Current pixel is see-through |

## Verification
The enable gating is driven with all eight combinations of the master and window bits, so that a missing AND term or a swapped window shows up. The wipe is run with a host write held active the whole time and a second wipe command issued partway through. This separates correct address stepping, exact length, port blocking and restart protection. The blink period is tried at 1, 2, 31 and 0, with samples one pulse before and at each expected flip, which catches off-by-one counts and a wrong multiplier. The transparency test drives black and non-black colours at attributes 0, 7, 8 and 15 with the override bit on and off.

// File: rtl/osd_frame_ctrl.sv
module osd_frame_ctrl #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 16,
  parameter int PAL_W        = 8,
  parameter int ATTR_W       = 4,
  parameter int BLINK_W      = 5,
  parameter int BLINK_SHIFT  = 3,
  parameter int TRANSP_ATTRS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              vsync,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              clr_busy,
  output logic              win_a_on,
  output logic              win_b_on,
  output logic              blink_visible,
  input  logic [ATTR_W-1:0] pix_attr,
  input  logic [PAL_W-1:0]  pix_color,
  output logic              pix_transparent
);
  localparam int CNT_W = BLINK_W + BLINK_SHIFT;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic               master_en, wa_en, wb_en, tr_off, phase;
  logic [BLINK_W-1:0] period;
  logic [ADDR_W-1:0]  wipe_addr;
  logic [CNT_W-1:0]   fcnt, fields;

  wire ctl_wr   = reg_we && !reg_sel;
  wire blink_wr = reg_we && reg_sel;

  assign fields = {period, {BLINK_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      wa_en     <= 1'b0;
      wb_en     <= 1'b0;
      tr_off    <= 1'b0;
      period    <= '0;
      clr_busy  <= 1'b0;
      wipe_addr <= '0;
      fcnt      <= '0;
      phase     <= 1'b0;
    end else begin
      if (ctl_wr) begin
        master_en <= reg_wdata[0];
        wa_en     <= reg_wdata[1];
        wb_en     <= reg_wdata[2];
        tr_off    <= reg_wdata[4];
      end
      if (clr_busy) begin
        wipe_addr <= wipe_addr + ADDR_W'(1);
        if (wipe_addr == LAST_ADDR) clr_busy <= 1'b0;
      end else if (ctl_wr && reg_wdata[3]) begin
        clr_busy  <= 1'b1;
        wipe_addr <= '0;
      end
      if (blink_wr) begin
        period <= reg_wdata[BLINK_W-1:0];
        fcnt   <= '0;
        if (reg_wdata[BLINK_W-1:0] == '0) phase <= 1'b0;
      end else if (period == '0) begin
        fcnt  <= '0;
        phase <= 1'b0;
      end else if (vsync) begin
        if (fcnt == fields - CNT_W'(1)) begin
          fcnt  <= '0;
          phase <= ~phase;
        end else begin
          fcnt <= fcnt + CNT_W'(1);
        end
      end
    end
  end

  assign win_a_on      = master_en & wa_en;
  assign win_b_on      = master_en & wb_en;
  assign blink_visible = ~phase;

  assign reg_rdata = reg_sel ? {{(8-BLINK_W){1'b0}}, period}
                             : {3'b000, tr_off, clr_busy, wb_en, wa_en, master_en};

  assign mem_we    = clr_busy | host_we;
  assign mem_addr  = clr_busy ? wipe_addr : host_addr;
  assign mem_wdata = clr_busy ? '0 : host_wdata;

  assign pix_transparent = !tr_off && (pix_color == '0) &&
                           ({1'b0, pix_attr} < (ATTR_W+1)'(TRANSP_ATTRS));

  a_r3_master_off_kills_windows: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !reg_wdata[0] |=> !win_a_on && !win_b_on);

  a_r5_wipe_writes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> mem_we && mem_wdata == '0);

  a_r5_wipe_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy && $past(clr_busy) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

  a_r7_wipe_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy && mem_addr != LAST_ADDR |=> clr_busy);

  a_r8_blink_only_on_field: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync && !blink_wr |=> $stable(blink_visible));

  a_r10_high_attr_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pix_attr} >= (ATTR_W+1)'(TRANSP_ATTRS) |-> !pix_transparent);
endmodule

// File: tb/osd_frame_ctrl_bench.sv
module osd_frame_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0, vsync = 0, host_we = 0;
  logic [7:0] reg_wdata = 0, pix_color = 0;
  logic [8:0] host_addr = 0;
  logic [15:0] host_wdata = 0;
  logic [3:0] pix_attr = 0;
  logic [7:0] reg_rdata;
  logic mem_we, clr_busy, win_a_on, win_b_on, blink_visible, pix_transparent;
  logic [8:0] mem_addr;
  logic [15:0] mem_wdata;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  osd_frame_ctrl u_osd_frame_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input bit sel, output logic [7:0] v);
    reg_sel = sel; #1 v = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v0, v1;
    rd(0, v0); rd(1, v1);
    chk(!win_a_on && !win_b_on && !clr_busy && blink_visible && v0 == 0 && v1 == 0,
        "R1", {win_a_on, win_b_on, clr_busy, blink_visible}, 4'b0001);
  endtask

  task automatic t_windows();
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      wr(0, {5'b11100, k[2:0]});
      chk(win_a_on == (k[0] & k[1]) && win_b_on == (k[0] & k[2]),
          k[0] ? "R2" : "R3", {win_a_on, win_b_on}, {k[0] & k[1], k[0] & k[2]});
      rd(0, v);
      chk(v == {5'b00000, k[2:0]}, "R4 frame readback", v, {5'b0, k[2:0]});
    end
    begin
      logic [7:0] v;
      wr(1, 8'hff); rd(1, v);
      chk(v == 8'h1f, "R4 blink readback", v, 8'h1f);
      wr(0, 8'h10); rd(0, v);
      chk(v == 8'h10, "R4 override bit", v, 8'h10);
      wr(0, 8'h00);
    end
  endtask

  task automatic t_wipe();
    int errs = 0;
    logic [7:0] v;
    host_we = 1; host_addr = 9'h055; host_wdata = 16'hbeef;
    #1 chk(mem_we && mem_addr == 9'h055 && mem_wdata == 16'hbeef, "R6 passthrough", mem_addr, 9'h055);
    wr(0, 8'h0b);
    rd(0, v);
    chk(v == 8'h0b, "R4 busy readback", v, 8'h0b);
    for (int i = 0; i < 512; i++) begin
      #1;
      if (!(clr_busy && mem_we && mem_addr == i[8:0] && mem_wdata == 0)) errs++;
      if (i == 100) begin
        reg_we = 1; reg_sel = 0; reg_wdata = 8'h0d;
      end
      if (i == 101) reg_we = 0;
      if (i == 105) chk(win_b_on && !win_a_on, "R7 other bits applied", {win_a_on, win_b_on}, 2'b01);
      @(negedge clk);
    end
    chk(errs == 0, "R5 wipe sequence", errs, 0);
    chk(errs == 0, "R6 host blocked / R7 no restart", errs, 0);
    #1 rd(0, v);
    chk(!clr_busy && v[3] == 0, "R5 wipe ends", v, 8'h05);
    chk(mem_addr == 9'h055 && mem_wdata == 16'hbeef, "R6 port returned", mem_addr, 9'h055);
    host_we = 0;
    wr(0, 8'h00);
  endtask

  task automatic t_blink(input logic [4:0] p);
    bit start = blink_visible;
    wr(1, {3'b0, p});
    for (int n = 1; n < 8 * p; n++) pulse();
    #1 chk(blink_visible == start, "R8 before period", blink_visible, start);
    pulse();
    #1 chk(blink_visible == !start, "R8 at period", blink_visible, !start);
  endtask

  task automatic t_blink_zero();
    wr(1, 8'd1);
    for (int n = 0; n < 8; n++) pulse();
    #1 chk(!blink_visible, "R8 hidden phase", blink_visible, 0);
    wr(1, 8'd0);
    #1 chk(blink_visible, "R9 zero forces visible", blink_visible, 1);
    for (int n = 0; n < 20; n++) pulse();
    #1 chk(blink_visible, "R9 vsync ignored", blink_visible, 1);
  endtask

  task automatic t_transp();
    int a[4] = '{0, 7, 8, 15};
    for (int o = 0; o < 2; o++) begin
      wr(0, o[0] ? 8'h10 : 8'h00);
      foreach (a[j]) begin
        for (int c = 0; c < 2; c++) begin
          bit e;
          pix_attr = a[j][3:0]; pix_color = c[0] ? 8'h40 : 8'h00;
          e = (o == 0) && (c == 0) && (a[j] < 8);
          #1 chk(pix_transparent == e, "R10", pix_transparent, e);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_windows();
    t_wipe();
    t_blink(5'd1);
    t_blink(5'd1);
    t_blink(5'd2);
    t_blink(5'd31);
    t_blink_zero();
    t_transp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule